// File: doc/BRIEF.md
# Multi-Select SPI Master with Per-Target Timing

This block is a mode-0 SPI master that serves up to four peripherals, one at a time, through active-low select lines. Each select has its own stored settings: a clock divisor, a lead-in delay that runs from the select going low to the start of clocking, and a spacing delay between two transfers aimed at that same select. One shared setting holds the pause that separates the release of one select from the assertion of another. Because the settings live per select, software moves between slow and fast peripherals without rewriting anything between transfers.

A request carries a byte, a target select and a hold flag. It is taken in any cycle where `req_ready` is high. The byte goes out most significant bit first, and the byte shifted in from the peripheral comes back with a one-cycle done pulse. A request aimed at a select whose divisor is zero is refused, and an error pulse is raised in its place. The hold flag keeps the select low after the transfer, so a multi-byte exchange can keep the peripheral framed.

Top module: `spi_seq_master`

## Requirements
- R1: Out of reset, every select line is high, `spi_sclk`, `spi_mosi`, `busy`, `rsp_done` and `xfer_err` are low, and `req_ready` is high.
- R2: With divisor D (1 to 255), each of the 8 bits gives D cycles of `spi_sclk` low followed by D cycles high. `spi_sclk` is low whenever no bits are being shifted.
- R3: A request whose target divisor is 0 starts nothing. The cycle after acceptance has `xfer_err` high for exactly one cycle, `busy` low, no done pulse, and select lines unchanged, including a select that is being held.
- R4: All stored divisors, delays and the gap are 0 after reset, so a request made before any setting is written is refused as in R3.
- R5: A transfer uses the divisor, lead-in delay and spacing delay stored for its own target select, written through `cfg_we` with index `cfg_sel`.
- R6: When the previous transfer went to a different select, the block waits `gap_val` cycles with every select high before it asserts the new select. This holds whether the old select was released or still held. The first transfer after reset has no gap.
- R7: Unless the target select is already held, the target select is low for S cycles (its lead-in setting) before the shift phase begins. The first rising `spi_sclk` edge therefore follows the select falling edge by S + D cycles.
- R8: When the previous transfer went to the same select, the block waits C cycles (that select's spacing setting) before the next step. The select stays low during that wait if it was held, and high otherwise. If it was held, the shift phase follows directly, with no lead-in.
- R9: `spi_mosi` carries the request byte most significant bit first. It changes only when shifting starts or on a falling `spi_sclk` edge.
- R10: `spi_miso` is sampled on each rising `spi_sclk` edge, first sample as the most significant bit, and the byte appears on `rsp_data` during the done cycle.
- R11: With the hold flag set, the target select stays low after the done cycle. Without it, the select goes high in the done cycle.
- R12: `busy` is high from the cycle after acceptance until the done cycle, where it is low. `rsp_done` is a single-cycle pulse, and `req_ready` equals the inverse of `busy`.
- R13: At most one select line is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the per-select settings of `cfg_sel` |
| cfg_sel | input | 2 | Select index being configured |
| cfg_div | input | 8 | Clock divisor (0 is illegal) |
| cfg_setup | input | 8 | Lead-in cycles from select low to shifting |
| cfg_b2b | input | 8 | Spacing cycles between transfers to the same select |
| gap_we | input | 1 | Write the shared select-change gap |
| gap_val | input | 8 | Gap cycles between different selects |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sel | input | 2 | Target select of the request |
| req_data | input | 8 | Byte to send |
| req_hold | input | 1 | Keep the select low after this transfer |
| rsp_done | output | 1 | One-cycle end-of-transfer pulse |
| rsp_data | output | 8 | Received byte, valid with `rsp_done` |
| xfer_err | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | Transfer sequence under way |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low select lines |

## Verification
The hardest situation to reach is a select change while the old select is still held. In that case the gap must release the old line before any lead-in runs, and a zero gap must switch from one low line to another with no high cycle between them. The stimulus builds a held chain on one select, then jumps to another select with a non-zero gap. It then sets the gap to zero and repeats the jump, and it sends a refused request while a select is held. A behavioural model turns each accepted request into a cycle-by-cycle list of expected line values. That list is compared against the pins on every clock, so every delay length is checked to the exact cycle.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SETUP = 2'd2,
    ST_SHIFT = 2'd3
  } seq_state_e;

  // Wait inserted before the select step of a new transfer.
  function automatic logic [CFG_W-1:0] lead_wait(
    input logic             seen,
    input logic             same_sel,
    input logic [CFG_W-1:0] b2b,
    input logic [CFG_W-1:0] gap
  );
    if (!seen)         return '0;
    else if (same_sel) return b2b;
    else               return gap;
  endfunction

  // Cycles spent in the shift phase for a divisor.
  function automatic int unsigned shift_len(input int unsigned bits, input int unsigned div);
    return bits * 2 * div;
  endfunction

endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
  parameter int NUM_CS = 4,
  parameter int CW     = spi_seq_pkg::CFG_W,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CW-1:0]    wr_div,
  input  logic [CW-1:0]    wr_setup,
  input  logic [CW-1:0]    wr_b2b,
  input  logic             gap_we,
  input  logic [CW-1:0]    gap_in,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CW-1:0]    rd_div,
  output logic [CW-1:0]    rd_setup,
  output logic [CW-1:0]    rd_b2b,
  output logic [CW-1:0]    gap_out
);

  logic [CW-1:0] div_r   [NUM_CS];
  logic [CW-1:0] setup_r [NUM_CS];
  logic [CW-1:0] b2b_r   [NUM_CS];
  logic [CW-1:0] gap_r;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    wire hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_r[g]   <= '0;
        setup_r[g] <= '0;
        b2b_r[g]   <= '0;
      end else if (hit) begin
        div_r[g]   <= wr_div;
        setup_r[g] <= wr_setup;
        b2b_r[g]   <= wr_b2b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_r <= '0;
    else if (gap_we) gap_r <= gap_in;
  end

  assign rd_div   = div_r[rd_sel];
  assign rd_setup = setup_r[rd_sel];
  assign rd_b2b   = b2b_r[rd_sel];
  assign gap_out  = gap_r;

  // R4: a slot never written keeps a zero divisor
  assert_cfg_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_sel)) |-> $stable(rd_div));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8,
  parameter int CW = spi_seq_pkg::CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] div_i,
  input  logic [DW-1:0] tx_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          fin_o,
  output logic [DW-1:0] rx_o
);

  localparam int BW = $clog2(DW);

  logic          active;
  logic [CW-1:0] div_q;
  logic [CW-1:0] hcnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic [DW-1:0] rx;

  wire half_end = active && (hcnt == '0);
  wire last_bit = (bitn == BW'(DW - 1));
  wire rise_evt = half_end && !sclk_o;
  wire fall_evt = half_end && sclk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      div_q  <= '0;
      hcnt   <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
    end else if (start_i) begin
      active <= 1'b1;
      div_q  <= div_i;
      hcnt   <= div_i - CW'(1);
      bitn   <= '0;
      sh     <= tx_i;
      sclk_o <= 1'b0;
      mosi_o <= tx_i[DW-1];
    end else if (rise_evt) begin
      sclk_o <= 1'b1;
      rx     <= {rx[DW-2:0], miso_i};
      hcnt   <= div_q - CW'(1);
    end else if (fall_evt) begin
      sclk_o <= 1'b0;
      hcnt   <= div_q - CW'(1);
      if (last_bit) begin
        active <= 1'b0;
      end else begin
        bitn   <= bitn + BW'(1);
        sh     <= {sh[DW-2:0], 1'b0};
        mosi_o <= sh[DW-2];
      end
    end else if (active) begin
      hcnt <= hcnt - CW'(1);
    end
  end

  assign fin_o = fall_evt && last_bit;
  assign rx_o  = rx;

  // R9: data out moves only at shift start or with a falling clock
  assert_mosi_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> ($past(start_i) || $fell(sclk_o)));

  // R10: the receive register moves only together with a rising clock
  assert_rx_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx) |-> $rose(sclk_o));

endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DW     = 8,
  parameter int CW     = CFG_W,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CW-1:0]    cfg_div,
  input  logic [CW-1:0]    cfg_setup,
  input  logic [CW-1:0]    cfg_b2b,
  input  logic             gap_we,
  input  logic [CW-1:0]    gap_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [DW-1:0]    req_data,
  input  logic             req_hold,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_data,
  output logic             xfer_err,
  output logic             busy,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic [SEL_W-1:0] cur;
  logic [SEL_W-1:0] last_cs;
  logic             seen_q, held_q, hold_q, keep_q;
  logic [DW-1:0]    tx_q;
  logic [CW-1:0]    div_q;
  logic             done_q, err_q;
  logic [DW-1:0]    rsp_q;

  logic [CW-1:0] rd_div, rd_setup, rd_b2b, gap_cur;
  wire  [SEL_W-1:0] rd_sel = (state == ST_IDLE) ? req_sel : cur;

  spi_cfg_bank #(.NUM_CS(NUM_CS), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_div(cfg_div),
    .wr_setup(cfg_setup), .wr_b2b(cfg_b2b),
    .gap_we(gap_we), .gap_in(gap_val),
    .rd_sel(rd_sel), .rd_div(rd_div), .rd_setup(rd_setup),
    .rd_b2b(rd_b2b), .gap_out(gap_cur)
  );

  // Named internal events
  wire take       = (state == ST_IDLE) && req_valid;
  wire take_bad   = take && (rd_div == '0);
  wire take_ok    = take && (rd_div != '0);
  wire same_sel   = seen_q && (last_cs == req_sel);
  wire keep_now   = held_q && (last_cs == req_sel);
  wire [CW-1:0] lead = lead_wait(seen_q, same_sel, rd_b2b, gap_cur);
  wire launch_keep  = (state == ST_IDLE) ? keep_now : keep_q;
  wire launch_shift = launch_keep || (rd_setup == '0);
  wire gap_end    = (state == ST_GAP) && (cnt == CW'(1));
  wire setup_end  = (state == ST_SETUP) && (cnt == CW'(1));
  wire after_gap  = (take_ok && lead == '0) || gap_end;
  wire shift_go   = (after_gap && launch_shift) || setup_end;
  wire eng_fin;
  wire [DW-1:0] eng_rx;
  wire [CW-1:0] eng_div = (state == ST_IDLE) ? rd_div : div_q;
  wire [DW-1:0] eng_tx  = (state == ST_IDLE) ? req_data : tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cur     <= '0;
      last_cs <= '0;
      seen_q  <= 1'b0;
      held_q  <= 1'b0;
      hold_q  <= 1'b0;
      keep_q  <= 1'b0;
      tx_q    <= '0;
      div_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rsp_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= take_bad;
      if (take_ok) begin
        cur     <= req_sel;
        last_cs <= req_sel;
        seen_q  <= 1'b1;
        held_q  <= 1'b0;
        hold_q  <= req_hold;
        keep_q  <= keep_now;
        tx_q    <= req_data;
        div_q   <= rd_div;
        if (lead != '0) begin
          state <= ST_GAP;
          cnt   <= lead;
        end
      end
      if (after_gap) begin
        if (launch_shift) begin
          state <= ST_SHIFT;
        end else begin
          state <= ST_SETUP;
          cnt   <= rd_setup;
        end
      end else if (state == ST_GAP || state == ST_SETUP) begin
        if (setup_end) state <= ST_SHIFT;
        else           cnt   <= cnt - CW'(1);
      end
      if (state == ST_SHIFT && eng_fin) begin
        state  <= ST_IDLE;
        done_q <= 1'b1;
        rsp_q  <= eng_rx;
        held_q <= hold_q;
      end
    end
  end

  spi_shift_engine #(.DW(DW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(shift_go), .div_i(eng_div),
    .tx_i(eng_tx), .miso_i(spi_miso), .sclk_o(spi_sclk),
    .mosi_o(spi_mosi), .fin_o(eng_fin), .rx_o(eng_rx)
  );

  // Select line decode
  logic             cs_act;
  logic [SEL_W-1:0] cs_idx;
  always_comb begin
    unique case (state)
      ST_IDLE: begin cs_act = held_q; cs_idx = last_cs; end
      ST_GAP:  begin cs_act = keep_q; cs_idx = cur;     end
      default: begin cs_act = 1'b1;   cs_idx = cur;     end
    endcase
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_act && (cs_idx == SEL_W'(i)));
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_data  = rsp_q;
  assign xfer_err  = err_q;

  assert_one_select_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  assert_zero_div_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> (xfer_err && !busy && !rsp_done));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !spi_sclk);

  assert_cs_in_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> !spi_cs_n[cur]);

  assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);

endmodule

// File: tb/tb_spi_seq_master.sv
module tb_spi_seq_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, gap_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_div = '0, cfg_setup = '0, cfg_b2b = '0, gap_val = '0;
  logic       req_valid = 1'b0, req_hold = 1'b0;
  logic       req_ready;
  logic [1:0] req_sel = '0;
  logic [7:0] req_data = '0;
  logic       rsp_done, xfer_err, busy, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;
  logic [7:0] rsp_data;
  logic [3:0] spi_cs_n;

  always #4 clk = ~clk;

  spi_seq_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_b2b(cfg_b2b),
    .gap_we(gap_we), .gap_val(gap_val), .req_valid(req_valid),
    .req_ready(req_ready), .req_sel(req_sel), .req_data(req_data),
    .req_hold(req_hold), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .xfer_err(xfer_err), .busy(busy), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model state
  typedef struct packed {
    logic [3:0] csn;
    logic       sclk;
    logic       bsy;
    logic       dn;
    logic       er;
  } exp_t;

  exp_t       eq[$];
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [3:0] idle_csn = 4'hF;
  int  mdiv[4], msu[4], mb2b[4];
  int  mgap = 0;
  bit  m_seen = 0, m_held = 0;
  int  m_last = 0;
  bit  checking = 0;
  logic [7:0] sbyte = '0;

  function automatic logic [3:0] low_of(input int s);
    return ~(4'b0001 << s);
  endfunction

  task automatic push(input logic [3:0] c, input logic s, input logic b, input logic d, input logic e);
    exp_t x;
    x.csn = c; x.sclk = s; x.bsy = b; x.dn = d; x.er = e;
    eq.push_back(x);
  endtask

  task automatic wr_cfg(input int s, input int d, input int su, input int bb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_div = 8'(d); cfg_setup = 8'(su); cfg_b2b = 8'(bb);
    @(negedge clk);
    cfg_we = 1'b0;
    mdiv[s] = d; msu[s] = su; mb2b[s] = bb;
  endtask

  task automatic wr_gap(input int g);
    @(negedge clk);
    gap_we = 1'b1; gap_val = 8'(g);
    @(negedge clk);
    gap_we = 1'b0;
    mgap = g;
  endtask

  // Issue one request and build the expected waveform from the requirements
  task automatic do_req(input int s, input logic [7:0] d, input bit hold, input logic [7:0] resp);
    int  dv, lead;
    bit  keep;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sbyte = resp;
    req_valid = 1'b1; req_sel = 2'(s); req_data = d; req_hold = hold;
    @(posedge clk);
    dv = mdiv[s];
    if (dv == 0) begin
      push(idle_csn, 1'b0, 1'b0, 1'b0, 1'b1);          // R3 R4
    end else begin
      keep = m_held && (m_last == s);
      lead = !m_seen ? 0 : ((m_last == s) ? mb2b[s] : mgap);   // R6 R8
      for (int k = 0; k < lead; k++) push(keep ? low_of(s) : 4'hF, 1'b0, 1'b1, 1'b0, 1'b0);
      if (!keep) for (int k = 0; k < msu[s]; k++) push(low_of(s), 1'b0, 1'b1, 1'b0, 1'b0); // R7
      for (int k = 0; k < 16 * dv; k++) push(low_of(s), (k % (2 * dv)) >= dv, 1'b1, 1'b0, 1'b0); // R2 R5
      push(hold ? low_of(s) : 4'hF, 1'b0, 1'b0, 1'b1, 1'b0);  // R11 R12
      idle_csn = hold ? low_of(s) : 4'hF;
      m_seen = 1; m_last = s; m_held = hold;
      rxq.push_back(resp);
      txq.push_back(d);
    end
    #1 req_valid = 1'b0;
  endtask

  // Monitor, slave model and per-cycle comparison
  logic       prev_sclk = 1'b0;
  int         falls = 0;
  logic [7:0] mon_mosi = '0;

  always @(negedge clk) begin
    exp_t x;
    if (checking) begin
      if (prev_sclk == 1'b0 && spi_sclk == 1'b1) mon_mosi = {mon_mosi[6:0], spi_mosi};
      if (eq.size() > 0) x = eq.pop_front();
      else begin
        x.csn = idle_csn; x.sclk = 1'b0; x.bsy = 1'b0; x.dn = 1'b0; x.er = 1'b0;
      end
      check(spi_cs_n === x.csn, "R6 R7 R8 R11 R13 select lines", spi_cs_n, x.csn);
      check(spi_sclk === x.sclk, "R2 R5 serial clock", spi_sclk, x.sclk);
      check(busy === x.bsy && req_ready === !x.bsy, "R12 busy/ready", busy, x.bsy);
      check(rsp_done === x.dn, "R12 done pulse", rsp_done, x.dn);
      check(xfer_err === x.er, "R3 error pulse", xfer_err, x.er);
      if (x.dn && rxq.size() > 0) begin
        logic [7:0] er, et;
        er = rxq.pop_front();
        et = txq.pop_front();
        check(rsp_data === er, "R10 received byte", rsp_data, er);
        check(mon_mosi === et, "R9 sent byte MSB first", mon_mosi, et);
      end
    end
    if (&spi_cs_n) falls = 0;
    else if (prev_sclk && !spi_sclk) falls++;
    prev_sclk = spi_sclk;
    spi_miso = sbyte[7 - (falls % 8)];
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mdiv[i] = 0; msu[i] = 0; mb2b[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n === 4'hF, "R1 selects high", spi_cs_n, 4'hF);
    check({spi_sclk, spi_mosi, busy, rsp_done, xfer_err} === 5'b0, "R1 outputs low",
          {spi_sclk, spi_mosi, busy, rsp_done, xfer_err}, 0);
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);
    checking = 1;

    // R4: settings are zero after reset, so this is refused
    do_req(0, 8'h11, 1'b0, 8'h22);

    wr_cfg(0, 1, 0, 0);
    wr_cfg(1, 3, 2, 4);
    wr_cfg(2, 2, 5, 1);
    wr_cfg(3, 255, 0, 2);
    wr_gap(3);

    do_req(0, 8'hA5, 1'b0, 8'h5A);   // first transfer, fastest divisor
    do_req(0, 8'h3C, 1'b0, 8'hC3);   // same select, zero spacing
    do_req(1, 8'h81, 1'b1, 8'h96);   // gap, then lead-in, then held
    do_req(1, 8'h7E, 1'b1, 8'h01);   // held same select: spacing, no lead-in
    do_req(1, 8'h55, 1'b0, 8'hFF);   // release after done
    do_req(2, 8'hF0, 1'b1, 8'h0F);   // different select, held
    do_req(3, 8'h96, 1'b0, 8'h69);   // held different select, slowest divisor
    do_req(3, 8'h24, 1'b0, 8'h42);   // released same select, spacing with line high
    wr_gap(0);
    do_req(2, 8'hC9, 1'b1, 8'h3B);
    do_req(0, 8'h12, 1'b1, 8'hED);   // zero gap: direct switch between held selects
    wr_cfg(3, 0, 0, 0);
    do_req(3, 8'h77, 1'b0, 8'h88);   // R3: refused while select 0 is held
    do_req(0, 8'h6B, 1'b0, 8'hB6);   // still held, continues on select 0

    while (eq.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule